// File: doc/BRIEF.md
# UART FIFO Ready-Pin Controller

This block produces the two active-low ready outputs of a UART whose transmit and receive paths each carry a 32-entry FIFO. It watches a copy of the FIFO control byte, the programmed receive trigger level, a one-cycle receive timeout pulse and the occupancy counts of both FIFOs. When FIFOs are off, those counts stand for the single holding registers and are 0 or 1. From these inputs it drives `rxrdy_n` and `txrdy_n`, which a block-transfer engine or a polling host uses to decide when to move data.

There are three behaviours. With FIFOs off, each pin follows its holding register. With FIFOs on in single-character mode, each pin follows simple empty or non-empty tests. With FIFOs on in block-transfer mode, the receive pin has hysteresis: it asserts at the trigger level or on a timeout and releases only when the FIFO drains. The transmit pin stays low until the FIFO is full. A small readback path returns the divisor latch bytes, or a fixed identity and revision pair when both latches are zero.

Top module: `uart_rdy_sig`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `rxrdy_n` is 1, `txrdy_n` is 0 and `rd_data` is 0x00.
- R2: With `ctl_byte` bit 0 = 0 (FIFOs off), bit 3 has no effect. `rxrdy_n` is 0 exactly when `rx_count` is nonzero, and `txrdy_n` is 1 exactly when `tx_count` is nonzero.
- R3: With bit 0 = 1 and bit 3 = 0, `rxrdy_n` is 0 while `rx_count` ≥ 1 and 1 when it is 0.
- R4: With bit 0 = 1 and bit 3 = 0, `txrdy_n` is 0 only when `tx_count` is 0. It is 1 for any count from 1 to 32.
- R5: With bits 0 and 3 both set, `rxrdy_n` goes to 0 when `rx_count` ≥ `rx_trig`, or when `rx_tmo` is high with `rx_count` nonzero.
- R6: In block mode, once `rxrdy_n` is 0 it stays 0 while `rx_count` is nonzero, even below the trigger level. It returns to 1 when `rx_count` is 0. An empty FIFO takes priority over a timeout in the same cycle.
- R7: In block mode, `txrdy_n` is 0 while `tx_count` < 32 and 1 when `tx_count` = 32.
- R8: Every output reflects the inputs of the previous clock edge. On entry into block mode, `rxrdy_n` is recomputed from the current count, trigger and timeout, so no earlier assertion carries over.
- R9: When both divisor latch inputs are 0x00, `rd_data` returns 0x04 for a high-latch read and 0x01 for a low-latch read. Otherwise it returns the selected latch byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_byte | input | 8 | FIFO control byte; bit 0 enables the FIFOs, bit 3 selects block mode |
| rx_trig | input | 6 | Receive trigger level in bytes |
| rx_tmo | input | 1 | Receive timeout pulse |
| rx_count | input | 6 | Receive FIFO / holding register occupancy |
| tx_count | input | 6 | Transmit FIFO / holding register occupancy |
| div_lo | input | 8 | Low divisor latch value |
| div_hi | input | 8 | High divisor latch value |
| rd_hi_sel | input | 1 | 1 selects a high-latch read, 0 a low-latch read |
| rxrdy_n | output | 1 | Receive ready, active low |
| txrdy_n | output | 1 | Transmit ready, active low |
| rd_data | output | 8 | Readback byte |

## Verification
In block mode, a receive timeout pulse and the receive FIFO reaching empty can arrive on the same edge, and the two push `rxrdy_n` in opposite directions. The bench drives `rx_tmo` high in the same cycle that it drives `rx_count` to 0 after the pin has been held low. It expects `rxrdy_n` to be 1 one clock later. A second collision, a mode change in the same cycle that the count crosses the trigger level, is driven and judged against a value recomputed from that cycle's count.

// File: rtl/uart_rdy_pkg.sv
package uart_rdy_pkg;
    localparam int FIFO_DEPTH = 32;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
    localparam int EN_BIT     = 0;
    localparam int BLK_BIT    = 3;
    localparam logic [7:0] DEV_ID  = 8'h04;
    localparam logic [7:0] DEV_REV = 8'h01;

    typedef enum logic [1:0] {
        MODE_BYTE   = 2'd0,
        MODE_SINGLE = 2'd1,
        MODE_BLOCK  = 2'd2
    } rdy_mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] trig;
        logic             tmo;
    } rx_view_t;

    function automatic rdy_mode_e decode_mode(input logic [7:0] ctl);
        if (!ctl[EN_BIT])
            return MODE_BYTE;
        else if (ctl[BLK_BIT])
            return MODE_BLOCK;
        else
            return MODE_SINGLE;
    endfunction
endpackage

// File: rtl/rdy_rx.sv
module rdy_rx
    import uart_rdy_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rdy_mode_e mode,
    input  rx_view_t  rx,
    output logic      rxrdy_n
);
    logic rx_n_q, rx_n_d;
    logic in_blk_q;
    logic empty, reached;

    assign empty   = (rx.count == '0);
    assign reached = (rx.count >= rx.trig) || rx.tmo;

    always_comb begin
        rx_n_d = rx_n_q;
        unique case (mode)
            MODE_BLOCK: begin
                if (empty)
                    rx_n_d = 1'b1;
                else if (reached)
                    rx_n_d = 1'b0;
                else if (!in_blk_q)
                    rx_n_d = 1'b1;
            end
            default: rx_n_d = empty;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_n_q   <= 1'b1;
            in_blk_q <= 1'b0;
        end else begin
            rx_n_q   <= rx_n_d;
            in_blk_q <= (mode == MODE_BLOCK);
        end
    end

    assign rxrdy_n = rx_n_q;

    AST_RX_EMPTY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (rx.count == '0) |=> rxrdy_n);                                     // R6
    AST_RX_TRIG_ASSERT: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BLOCK && rx.count != '0 && rx.count >= rx.trig) |=> !rxrdy_n); // R5
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BLOCK && in_blk_q && rx.count != '0 && rx.count < rx.trig && !rx.tmo)
        |=> (rxrdy_n == $past(rxrdy_n)));                                  // R6
    AST_RX_ENTRY_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BLOCK && !in_blk_q && rx.count < rx.trig && !rx.tmo) |=> rxrdy_n); // R8
    AST_RX_SIMPLE: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_BLOCK && rx.count != '0) |=> !rxrdy_n);              // R3
endmodule

// File: rtl/rdy_tx.sv
module rdy_tx
    import uart_rdy_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  rdy_mode_e     mode,
    input  logic [CW-1:0] count,
    output logic          txrdy_n
);
    logic tx_n_q, tx_n_d;

    always_comb begin
        if (mode == MODE_BLOCK)
            tx_n_d = (count >= CW'(DEPTH));
        else
            tx_n_d = (count != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) tx_n_q <= 1'b0;
        else     tx_n_q <= tx_n_d;
    end

    assign txrdy_n = tx_n_q;

    AST_TX_FULL: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BLOCK && count == CW'(DEPTH)) |=> txrdy_n);          // R7
    AST_TX_ROOM: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BLOCK && count < CW'(DEPTH)) |=> !txrdy_n);          // R7
    AST_TX_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_BLOCK && count != '0) |=> txrdy_n);                  // R4
endmodule

// File: rtl/id_readback.sv
module id_readback
    import uart_rdy_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] div_lo,
    input  logic [7:0] div_hi,
    input  logic       hi_sel,
    output logic [7:0] rd_data
);
    logic [7:0] rd_q, rd_d;
    logic       id_window;

    assign id_window = (div_lo == 8'h00) && (div_hi == 8'h00);

    always_comb begin
        if (id_window) rd_d = hi_sel ? DEV_ID : DEV_REV;
        else           rd_d = hi_sel ? div_hi : div_lo;
    end

    always_ff @(posedge clk) begin
        if (rst) rd_q <= 8'h00;
        else     rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    AST_ID_READ: assert property (@(posedge clk) disable iff (rst)
        (div_lo == 8'h00 && div_hi == 8'h00 && hi_sel) |=> (rd_data == 8'h04)); // R9
    AST_LATCH_READ: assert property (@(posedge clk) disable iff (rst)
        (div_hi != 8'h00 && hi_sel) |=> (rd_data == $past(div_hi)));          // R9
endmodule

// File: rtl/uart_rdy_sig.sv
module uart_rdy_sig
    import uart_rdy_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    ctl_byte,
    input  logic [CW-1:0] rx_trig,
    input  logic          rx_tmo,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic [7:0]    div_lo,
    input  logic [7:0]    div_hi,
    input  logic          rd_hi_sel,
    output logic          rxrdy_n,
    output logic          txrdy_n,
    output logic [7:0]    rd_data
);
    rdy_mode_e mode;
    rx_view_t  rx_view;

    assign mode = decode_mode(ctl_byte);
    assign rx_view.count = CNT_W'(rx_count);
    assign rx_view.trig  = CNT_W'(rx_trig);
    assign rx_view.tmo   = rx_tmo;

    rdy_rx u_rx (
        .clk(clk), .rst(rst), .mode(mode), .rx(rx_view), .rxrdy_n(rxrdy_n)
    );

    rdy_tx #(.DEPTH(DEPTH)) u_tx (
        .clk(clk), .rst(rst), .mode(mode), .count(tx_count), .txrdy_n(txrdy_n)
    );

    id_readback u_id (
        .clk(clk), .rst(rst), .div_lo(div_lo), .div_hi(div_hi),
        .hi_sel(rd_hi_sel), .rd_data(rd_data)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (rxrdy_n && !txrdy_n && rd_data == 8'h00));               // R1
    AST_BIT3_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!ctl_byte[0] && rx_count == '0 && tx_count == '0) |=> (rxrdy_n && !txrdy_n)); // R2
endmodule

// File: tb/uart_rdy_sig_tb.sv
module uart_rdy_sig_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] ctl_byte;
    logic [5:0] rx_trig, rx_count, tx_count;
    logic       rx_tmo, rd_hi_sel;
    logic [7:0] div_lo, div_hi, rd_data;
    logic       rxrdy_n, txrdy_n;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    uart_rdy_sig u_dut (
        .clk(clk), .rst(rst), .ctl_byte(ctl_byte), .rx_trig(rx_trig),
        .rx_tmo(rx_tmo), .rx_count(rx_count), .tx_count(tx_count),
        .div_lo(div_lo), .div_hi(div_hi), .rd_hi_sel(rd_hi_sel),
        .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n), .rd_data(rd_data)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FIFO-rdy FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive at negedge, let one posedge register it, sample just after.
    task automatic apply(input logic [7:0] ctl, input logic [5:0] rc, input logic [5:0] tc,
                         input logic tmo);
        @(negedge clk);
        ctl_byte = ctl; rx_count = rc; tx_count = tc; rx_tmo = tmo;
        @(posedge clk); #2;
    endtask

    task automatic t_reset;
        rst = 1; ctl_byte = 8'h09; rx_count = 6'd20; tx_count = 6'd32; rx_tmo = 1;
        rx_trig = 6'd8; div_lo = 8'h00; div_hi = 8'h00; rd_hi_sel = 1;
        repeat (3) @(posedge clk);
        #2;
        check({7'b0, rxrdy_n}, 8'h01, "R1 rxrdy_n");
        check({7'b0, txrdy_n}, 8'h00, "R1 txrdy_n");
        check(rd_data, 8'h00, "R1 rd_data");
        @(negedge clk); rst = 0;
    endtask

    task automatic t_byte_mode;
        apply(8'h08, 6'd1, 6'd1, 0);
        check({7'b0, rxrdy_n}, 8'h00, "R2 rx holding full");
        check({7'b0, txrdy_n}, 8'h01, "R2 tx holding full, bit3 ignored");
        apply(8'h08, 6'd0, 6'd0, 1);
        check({7'b0, rxrdy_n}, 8'h01, "R2 rx holding empty");
        check({7'b0, txrdy_n}, 8'h00, "R2 tx holding empty");
    endtask

    task automatic t_single_mode;
        apply(8'h01, 6'd5, 6'd0, 0);
        check({7'b0, rxrdy_n}, 8'h00, "R3 rx nonempty");
        check({7'b0, txrdy_n}, 8'h00, "R4 tx empty");
        apply(8'h01, 6'd0, 6'd3, 0);
        check({7'b0, rxrdy_n}, 8'h01, "R3 rx empty");
        check({7'b0, txrdy_n}, 8'h01, "R4 tx partial");
        apply(8'h01, 6'd0, 6'd32, 0);
        check({7'b0, txrdy_n}, 8'h01, "R4 tx full");
    endtask

    task automatic t_block_mode;
        rx_trig = 6'd8;
        apply(8'h09, 6'd3, 6'd31, 0);
        check({7'b0, rxrdy_n}, 8'h01, "R5 below trigger");
        check({7'b0, txrdy_n}, 8'h00, "R7 room left");
        apply(8'h09, 6'd8, 6'd32, 0);
        check({7'b0, rxrdy_n}, 8'h00, "R5 at trigger");
        check({7'b0, txrdy_n}, 8'h01, "R7 full");
        apply(8'h09, 6'd4, 6'd0, 0);
        check({7'b0, rxrdy_n}, 8'h00, "R6 hold below trigger");
        check({7'b0, txrdy_n}, 8'h00, "R7 empty");
        apply(8'h09, 6'd0, 6'd0, 0);
        check({7'b0, rxrdy_n}, 8'h01, "R6 release on empty");
        apply(8'h09, 6'd2, 6'd0, 1);
        check({7'b0, rxrdy_n}, 8'h00, "R5 timeout");
        apply(8'h09, 6'd1, 6'd0, 0);
        check({7'b0, rxrdy_n}, 8'h00, "R6 hold after timeout");
        apply(8'h09, 6'd0, 6'd0, 1);
        check({7'b0, rxrdy_n}, 8'h01, "R6 empty beats timeout");
    endtask

    task automatic t_mode_change;
        rx_trig = 6'd8;
        apply(8'h01, 6'd4, 6'd0, 0);
        check({7'b0, rxrdy_n}, 8'h00, "R3 single low");
        apply(8'h09, 6'd4, 6'd0, 0);
        check({7'b0, rxrdy_n}, 8'h01, "R8 entry recompute below trigger");
        apply(8'h01, 6'd9, 6'd0, 0);
        check({7'b0, rxrdy_n}, 8'h00, "R8 back to single");
        apply(8'h09, 6'd9, 6'd32, 0);
        check({7'b0, rxrdy_n}, 8'h00, "R8 entry at trigger");
        check({7'b0, txrdy_n}, 8'h01, "R8 tx full on entry");
        apply(8'h01, 6'd0, 6'd31, 0);
        check({7'b0, txrdy_n}, 8'h01, "R8 tx single partial");
    endtask

    task automatic t_readback;
        @(negedge clk); div_lo = 8'h00; div_hi = 8'h00; rd_hi_sel = 1;
        @(posedge clk); #2; check(rd_data, 8'h04, "R9 id");
        @(negedge clk); rd_hi_sel = 0;
        @(posedge clk); #2; check(rd_data, 8'h01, "R9 revision");
        @(negedge clk); div_lo = 8'h10;
        @(posedge clk); #2; check(rd_data, 8'h10, "R9 low latch");
        @(negedge clk); rd_hi_sel = 1;
        @(posedge clk); #2; check(rd_data, 8'h00, "R9 high latch zero");
        @(negedge clk); div_hi = 8'h02;
        @(posedge clk); #2; check(rd_data, 8'h02, "R9 high latch");
    endtask

    initial begin
        t_reset();
        t_byte_mode();
        t_single_mode();
        t_block_mode();
        t_mode_change();
        t_readback();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++; n_fails++;
                $display("FIFO-rdy FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule